// File: doc/BRIEF.md
# Last-Value Result Predictor with Confidence Gating

This block guesses the result of an instruction before it executes by returning the value that the same instruction address produced last time. A lookup port is driven from the front of a pipelined core with the instruction address. One cycle later it returns the remembered 64-bit result and a flag that says whether the guess is trusted enough to be used. An update port is driven once the real result is known. It carries the address, the computed result and whether that result agreed with the earlier guess. The block uses it to train its confidence and, where allowed, to refresh the remembered value.

Two direct-mapped tables are indexed by the instruction address. The value table holds a valid bit, a partial address tag and the last result. The smaller confidence table holds a 2-bit saturating counter with its own tag. A guess is only trusted at the two upper counter levels. At the top level the remembered value is also protected: one wrong outcome lowers the counter but does not replace the value. An update is read in one cycle and written in the next. A bypass lets updates to the same entry in consecutive cycles build on each other.

Top module: `lvp_predictor`

## Requirements
- R1: After reset no entry is valid, and every lookup reports the use flag low until that address has been trained by updates.
- R2: `lk_valid_o` is high in the cycle after a cycle with `lk_req_i` high, and the use flag and value then belong to the address presented in that earlier cycle.
- R3: The first update of an address whose entry misses stores its result with a counter of 0. A later lookup returns that value with the use flag low.
- R4: An update with `up_match_i` high raises the counter by one, saturating at 3. The use flag is high only while the counter is 2 or 3.
- R5: An update with `up_match_i` low lowers the counter by one, saturating at 0.
- R6: An update with `up_match_i` low, applied while the counter is 0, 1 or 2, replaces the stored value with `up_value_i`.
- R7: An update with `up_match_i` low, applied while the counter is 3, leaves the stored value unchanged and lowers the counter to 2, so the use flag stays high.
- R8: Address bits [1:0] are ignored, bits [13:2] select the value entry and bits [21:14] form its tag. An address with the same index but a different tag misses (use flag low). Its update takes over the entry with a counter of 0, and the former owner then misses.
- R9: Bits [11:2] select the confidence entry and bits [21:12] form its tag. Allocating an address that shares bits [11:2] with a trained address forces the trained address's use flag low. Its next matching update restarts its counter at 1.
- R10: A lookup presented in the same cycle as an update of the same entry, or in the cycle after it, sees the contents from before that update. A lookup presented two or more cycles after the update sees the updated contents.
- R11: Updates of the same entry in consecutive cycles all take effect, each one building on the one before.
- R12: In a cycle after one with `lk_req_i` low, both `lk_valid_o` and `lk_use_o` are low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_i | input | 1 | Synchronous active-high reset |
| lk_req_i | input | 1 | Lookup request |
| lk_pc_i | input | 32 | Instruction address to look up |
| lk_valid_o | output | 1 | Lookup result is present this cycle |
| lk_use_o | output | 1 | Predicted value is trusted |
| lk_value_o | output | 64 | Predicted result value |
| up_req_i | input | 1 | Update request |
| up_pc_i | input | 32 | Instruction address being trained |
| up_value_i | input | 64 | Actual computed result |
| up_match_i | input | 1 | Actual result agreed with the prediction |

## Verification
A lookup and an update of the same entry can fall in the same cycle. Because the update writes one cycle late, a lookup in the following cycle also collides with the table write. The bench drives both ports at the same address in one cycle and keeps the lookup asserted for two more cycles. The first two results must carry the old value and the third must carry the new one. It also issues three updates of one address on consecutive cycles, which only train the counter to a trusted level if the write-to-read bypass works.

// File: rtl/lvp_pkg.sv
package lvp_pkg;

  typedef logic [1:0] conf_t;

  localparam conf_t CONF_MIN = 2'd0;
  localparam conf_t CONF_USE = 2'd2;
  localparam conf_t CONF_MAX = 2'd3;

  // Saturating step of the confidence counter.
  function automatic conf_t conf_step(input conf_t c, input logic ok);
    conf_t r;
    if (ok) r = (c == CONF_MAX) ? c : c + 2'd1;
    else    r = (c == CONF_MIN) ? c : c - 2'd1;
    return r;
  endfunction

endpackage

// File: rtl/lvp_sdp_ram.sv
// Simple dual-port memory: one synchronous write port, one registered
// read port. A read of the address being written returns the old word.
module lvp_sdp_ram #(
  parameter int W     = 8,
  parameter int DEPTH = 1024
) (
  input  logic                     clk_i,
  input  logic                     we_i,
  input  logic [$clog2(DEPTH)-1:0] waddr_i,
  input  logic [W-1:0]             wdata_i,
  input  logic [$clog2(DEPTH)-1:0] raddr_i,
  output logic [W-1:0]             rdata_o
);

  logic [W-1:0] mem [DEPTH];

  always_ff @(posedge clk_i) begin
    if (we_i) mem[waddr_i] <= wdata_i;
  end

  always_ff @(posedge clk_i) begin
    rdata_o <= mem[raddr_i];
  end

endmodule

// File: rtl/lvp_valid_array.sv
// Resettable per-entry valid bits with two registered read ports.
module lvp_valid_array #(
  parameter int DEPTH = 4096
) (
  input  logic                     clk_i,
  input  logic                     rst_i,
  input  logic                     set_i,
  input  logic [$clog2(DEPTH)-1:0] set_idx_i,
  input  logic [$clog2(DEPTH)-1:0] ra_idx_i,
  output logic                     ra_q_o,
  input  logic [$clog2(DEPTH)-1:0] rb_idx_i,
  output logic                     rb_q_o
);

  logic [DEPTH-1:0] bits_q;

  always_ff @(posedge clk_i) begin
    if (rst_i)      bits_q <= '0;
    else if (set_i) bits_q[set_idx_i] <= 1'b1;
  end

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      ra_q_o <= 1'b0;
      rb_q_o <= 1'b0;
    end else begin
      ra_q_o <= bits_q[ra_idx_i];
      rb_q_o <= bits_q[rb_idx_i];
    end
  end

endmodule

// File: rtl/lvp_predictor.sv
module lvp_predictor
  import lvp_pkg::*;
#(
  parameter int PC_W     = 32,
  parameter int PC_LSB   = 2,
  parameter int XLEN     = 64,
  parameter int VT_DEPTH = 4096,
  parameter int CT_DEPTH = 1024,
  parameter int TAG_W    = 8
) (
  input  logic            clk_i,
  input  logic            rst_i,
  input  logic            lk_req_i,
  input  logic [PC_W-1:0] lk_pc_i,
  output logic            lk_valid_o,
  output logic            lk_use_o,
  output logic [XLEN-1:0] lk_value_o,
  input  logic            up_req_i,
  input  logic [PC_W-1:0] up_pc_i,
  input  logic [XLEN-1:0] up_value_i,
  input  logic            up_match_i
);

  localparam int VT_AW    = $clog2(VT_DEPTH);
  localparam int CT_AW    = $clog2(CT_DEPTH);
  localparam int CT_TAG_W = VT_AW - CT_AW + TAG_W;
  localparam int CW       = CT_TAG_W + $bits(conf_t);
  localparam int PC_TOP   = PC_LSB + VT_AW + TAG_W;
  localparam int NRD      = 2;
  localparam int RD_LK    = 0;
  localparam int RD_UP    = 1;

  // ---------------- address fields ----------------
  logic [VT_AW-1:0]    lk_vt_idx, up_vt_idx;
  logic [TAG_W-1:0]    lk_tag, up_tag;
  logic [CT_AW-1:0]    lk_ct_idx, up_ct_idx;
  logic [CT_TAG_W-1:0] lk_ctag, up_ctag;

  assign lk_vt_idx = lk_pc_i[PC_LSB +: VT_AW];
  assign lk_tag    = lk_pc_i[PC_LSB + VT_AW +: TAG_W];
  assign lk_ct_idx = lk_pc_i[PC_LSB +: CT_AW];
  assign lk_ctag   = lk_pc_i[PC_LSB + CT_AW +: CT_TAG_W];
  assign up_vt_idx = up_pc_i[PC_LSB +: VT_AW];
  assign up_tag    = up_pc_i[PC_LSB + VT_AW +: TAG_W];
  assign up_ct_idx = up_pc_i[PC_LSB +: CT_AW];
  assign up_ctag   = up_pc_i[PC_LSB + CT_AW +: CT_TAG_W];

  logic unused_pc_bits;
  assign unused_pc_bits = ^{lk_pc_i[PC_W-1:PC_TOP], lk_pc_i[PC_LSB-1:0],
                            up_pc_i[PC_W-1:PC_TOP], up_pc_i[PC_LSB-1:0]};

  // ---------------- table read/write wiring ----------------
  logic [VT_AW-1:0] tag_raddr  [NRD];
  logic [TAG_W-1:0] tag_q      [NRD];
  logic [CT_AW-1:0] conf_raddr [NRD];
  logic [CW-1:0]    conf_q     [NRD];

  assign tag_raddr[RD_LK]  = lk_vt_idx;
  assign tag_raddr[RD_UP]  = up_vt_idx;
  assign conf_raddr[RD_LK] = lk_ct_idx;
  assign conf_raddr[RD_UP] = up_ct_idx;

  // Update stage (second cycle of an update): registered request.
  logic                up_vld_q, up_match_q;
  logic [VT_AW-1:0]    up_vt_idx_q;
  logic [TAG_W-1:0]    up_tag_q;
  logic [CT_AW-1:0]    up_ct_idx_q;
  logic [CT_TAG_W-1:0] up_ctag_q;
  logic [XLEN-1:0]     up_val_q;

  logic          alloc, val_we, conf_we;
  logic [CW-1:0] conf_wdata;
  logic          vld_lk_q, vld_up_q;

  lvp_valid_array #(.DEPTH(VT_DEPTH)) u_valid (
    .clk_i     (clk_i),
    .rst_i     (rst_i),
    .set_i     (alloc),
    .set_idx_i (up_vt_idx_q),
    .ra_idx_i  (lk_vt_idx),
    .ra_q_o    (vld_lk_q),
    .rb_idx_i  (up_vt_idx),
    .rb_q_o    (vld_up_q)
  );

  lvp_sdp_ram #(.W(XLEN), .DEPTH(VT_DEPTH)) u_value (
    .clk_i   (clk_i),
    .we_i    (val_we),
    .waddr_i (up_vt_idx_q),
    .wdata_i (up_val_q),
    .raddr_i (lk_vt_idx),
    .rdata_o (lk_value_o)
  );

  // One copy of the tag and confidence arrays per read port.
  for (genvar g = 0; g < NRD; g++) begin : g_rd_copy
    lvp_sdp_ram #(.W(TAG_W), .DEPTH(VT_DEPTH)) u_tag (
      .clk_i   (clk_i),
      .we_i    (alloc),
      .waddr_i (up_vt_idx_q),
      .wdata_i (up_tag_q),
      .raddr_i (tag_raddr[g]),
      .rdata_o (tag_q[g])
    );
    lvp_sdp_ram #(.W(CW), .DEPTH(CT_DEPTH)) u_conf (
      .clk_i   (clk_i),
      .we_i    (conf_we),
      .waddr_i (up_ct_idx_q),
      .wdata_i (conf_wdata),
      .raddr_i (conf_raddr[g]),
      .rdata_o (conf_q[g])
    );
  end

  // ---------------- lookup side ----------------
  logic                lk_vld_q;
  logic [TAG_W-1:0]    lk_tag_q;
  logic [CT_TAG_W-1:0] lk_ctag_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) lk_vld_q <= 1'b0;
    else       lk_vld_q <= lk_req_i;
  end

  always_ff @(posedge clk_i) begin
    lk_tag_q  <= lk_tag;
    lk_ctag_q <= lk_ctag;
  end

  logic  lk_hit, lk_chit;
  conf_t lk_cnt;

  assign lk_hit     = vld_lk_q && (tag_q[RD_LK] == lk_tag_q);
  assign lk_chit    = (conf_q[RD_LK][CW-1 -: CT_TAG_W] == lk_ctag_q);
  assign lk_cnt     = conf_q[RD_LK][$bits(conf_t)-1:0];
  assign lk_valid_o = lk_vld_q;
  assign lk_use_o   = lk_vld_q && lk_hit && lk_chit && (lk_cnt >= CONF_USE);

  // ---------------- update side ----------------
  always_ff @(posedge clk_i) begin
    if (rst_i) up_vld_q <= 1'b0;
    else       up_vld_q <= up_req_i;
  end

  always_ff @(posedge clk_i) begin
    up_vt_idx_q <= up_vt_idx;
    up_tag_q    <= up_tag;
    up_ct_idx_q <= up_ct_idx;
    up_ctag_q   <= up_ctag;
    up_val_q    <= up_value_i;
    up_match_q  <= up_match_i;
  end

  // Bypass of the write committing in the same edge as the next read.
  logic             byp_vt_q, byp_ct_q;
  logic [TAG_W-1:0] byp_tag_q;
  logic [CW-1:0]    byp_conf_q;

  always_ff @(posedge clk_i) begin
    if (rst_i) begin
      byp_vt_q <= 1'b0;
      byp_ct_q <= 1'b0;
    end else begin
      byp_vt_q <= alloc && (up_vt_idx_q == up_vt_idx);
      byp_ct_q <= conf_we && (up_ct_idx_q == up_ct_idx);
    end
  end

  always_ff @(posedge clk_i) begin
    byp_tag_q  <= up_tag_q;
    byp_conf_q <= conf_wdata;
  end

  logic             e_valid, e_hit, e_chit;
  logic [TAG_W-1:0] e_tag;
  logic [CW-1:0]    e_conf;
  conf_t            e_cnt, new_cnt;

  always_comb begin
    e_valid = byp_vt_q ? 1'b1      : vld_up_q;
    e_tag   = byp_vt_q ? byp_tag_q : tag_q[RD_UP];
    e_conf  = byp_ct_q ? byp_conf_q : conf_q[RD_UP];
    e_hit   = e_valid && (e_tag == up_tag_q);
    e_chit  = (e_conf[CW-1 -: CT_TAG_W] == up_ctag_q);
    // A foreign confidence entry counts as level 0.
    e_cnt   = e_chit ? e_conf[$bits(conf_t)-1:0] : CONF_MIN;

    alloc   = up_vld_q && !e_hit;
    conf_we = up_vld_q;
    if (!e_hit) begin
      new_cnt = CONF_MIN;
      val_we  = up_vld_q;
    end else begin
      new_cnt = conf_step(e_cnt, up_match_q);
      val_we  = up_vld_q && !up_match_q && (e_cnt != CONF_MAX);
    end
    conf_wdata = {up_ctag_q, new_cnt};
  end

endmodule

// File: rtl/lvp_predictor_chk.sv
module lvp_predictor_chk #(
  parameter int PC_W = 32,
  parameter int XLEN = 64
) (
  input logic            clk_i,
  input logic            rst_i,
  input logic            lk_req_i,
  input logic [PC_W-1:0] lk_pc_i,
  input logic            lk_valid_o,
  input logic            lk_use_o,
  input logic [XLEN-1:0] lk_value_o,
  input logic            up_req_i,
  input logic [PC_W-1:0] up_pc_i,
  input logic [XLEN-1:0] up_value_i,
  input logic            up_match_i
);

  // Update requests seen since reset, saturating at 3.
  logic [1:0] upd_seen_q;

  always_ff @(posedge clk_i) begin
    if (rst_i)                             upd_seen_q <= 2'd0;
    else if (up_req_i && upd_seen_q != 2'd3) upd_seen_q <= upd_seen_q + 2'd1;
  end

  logic unused_chk;
  assign unused_chk = ^{lk_pc_i, lk_value_o, up_pc_i, up_value_i, up_match_i};

  assert_valid_follows_req_R2: assert property (@(posedge clk_i) disable iff (rst_i)
    lk_req_i |=> lk_valid_o);

  assert_idle_no_valid_R12: assert property (@(posedge clk_i) disable iff (rst_i)
    !lk_req_i |=> (!lk_valid_o && !lk_use_o));

  assert_use_implies_valid_R12: assert property (@(posedge clk_i) disable iff (rst_i)
    lk_use_o |-> lk_valid_o);

  // R1 / R4: trust needs at least two updates since reset.
  assert_use_needs_training_R4: assert property (@(posedge clk_i) disable iff (rst_i)
    lk_use_o |-> (upd_seen_q >= 2'd2));

endmodule

bind lvp_predictor lvp_predictor_chk #(.PC_W(PC_W), .XLEN(XLEN)) u_chk (
  .clk_i      (clk_i),
  .rst_i      (rst_i),
  .lk_req_i   (lk_req_i),
  .lk_pc_i    (lk_pc_i),
  .lk_valid_o (lk_valid_o),
  .lk_use_o   (lk_use_o),
  .lk_value_o (lk_value_o),
  .up_req_i   (up_req_i),
  .up_pc_i    (up_pc_i),
  .up_value_i (up_value_i),
  .up_match_i (up_match_i)
);

// File: tb/lvp_predictor_tb_top.sv
module lvp_predictor_tb_top;
  timeunit 1ns;
  timeprecision 1ps;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        lk_req = 1'b0;
  logic [31:0] lk_pc = '0;
  logic        lk_valid_o, lk_use_o;
  logic [63:0] lk_value_o;
  logic        up_req = 1'b0;
  logic [31:0] up_pc = '0;
  logic [63:0] up_value = '0;
  logic        up_match = 1'b0;

  int n_checks = 0;
  int n_fail   = 0;
  bit done     = 1'b0;

  always #10 clk = ~clk;

  lvp_predictor dut_i (
    .clk_i      (clk),
    .rst_i      (rst),
    .lk_req_i   (lk_req),
    .lk_pc_i    (lk_pc),
    .lk_valid_o (lk_valid_o),
    .lk_use_o   (lk_use_o),
    .lk_value_o (lk_value_o),
    .up_req_i   (up_req),
    .up_pc_i    (up_pc),
    .up_value_i (up_value),
    .up_match_i (up_match)
  );

  localparam logic [31:0] PC_A  = 32'h0000_0040;
  localparam logic [31:0] PC_E  = 32'h0000_0080;
  localparam logic [31:0] PC_EX = 32'h0000_4080;
  localparam logic [31:0] PC_P  = 32'h0000_00C0;
  localparam logic [31:0] PC_Q  = 32'h0000_10C0;
  localparam logic [31:0] PC_X  = 32'h0000_0100;
  localparam logic [31:0] PC_Y  = 32'h0000_0140;

  task automatic check(input string req, input string what,
                       input logic [63:0] act, input logic [63:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual=%h expected=%h", req, what, act, exp);
    end
  endtask

  task automatic lookup(input logic [31:0] pc, input logic exp_use,
                        input logic chk_val, input logic [63:0] exp_val,
                        input string req);
    @(negedge clk);
    lk_req = 1'b1; lk_pc = pc;
    @(negedge clk);
    lk_req = 1'b0;
    check(req, "lk_valid_o", {63'd0, lk_valid_o}, 64'd1);
    check(req, "lk_use_o", {63'd0, lk_use_o}, {63'd0, exp_use});
    if (chk_val) check(req, "lk_value_o", lk_value_o, exp_val);
  endtask

  task automatic update(input logic [31:0] pc, input logic [63:0] val,
                        input logic match);
    @(negedge clk);
    up_req = 1'b1; up_pc = pc; up_value = val; up_match = match;
    @(negedge clk);
    up_req = 1'b0;
  endtask

  task automatic t_reset;
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    check("R12", "valid after reset", {63'd0, lk_valid_o}, 64'd0);
    check("R1", "use after reset", {63'd0, lk_use_o}, 64'd0);
    lookup(32'h0000_0200, 1'b0, 1'b0, 64'd0, "R1");
    @(negedge clk);
    check("R12", "valid with no request", {63'd0, lk_valid_o}, 64'd0);
    check("R2", "use with no request", {63'd0, lk_use_o}, 64'd0);
  endtask

  task automatic t_alloc;
    lookup(PC_A, 1'b0, 1'b0, 64'd0, "R1");
    update(PC_A, 64'hA5A5_0000_1111_2222, 1'b0);
    lookup(PC_A, 1'b0, 1'b1, 64'hA5A5_0000_1111_2222, "R3");
  endtask

  task automatic t_train_and_lock;
    update(PC_A, 64'hA5A5_0000_1111_2222, 1'b1);              // 1
    lookup(PC_A, 1'b0, 1'b1, 64'hA5A5_0000_1111_2222, "R4");
    update(PC_A, 64'hA5A5_0000_1111_2222, 1'b1);              // 2
    lookup(PC_A, 1'b1, 1'b1, 64'hA5A5_0000_1111_2222, "R4");
    update(PC_A, 64'hA5A5_0000_1111_2222, 1'b1);              // 3
    update(PC_A, 64'hA5A5_0000_1111_2222, 1'b1);              // stays 3
    update(PC_A, 64'hBEEF_0000_0000_0001, 1'b0);              // 3 -> 2, kept
    lookup(PC_A, 1'b1, 1'b1, 64'hA5A5_0000_1111_2222, "R7");
    update(PC_A, 64'hBEEF_0000_0000_0001, 1'b0);              // 2 -> 1, replaced
    lookup(PC_A, 1'b0, 1'b1, 64'hBEEF_0000_0000_0001, "R6");
  endtask

  task automatic t_decay;
    update(PC_A, 64'h0000_0000_0000_0C0C, 1'b0);              // 1 -> 0
    update(PC_A, 64'h0000_0000_0000_0D0D, 1'b0);              // stays 0
    lookup(PC_A, 1'b0, 1'b1, 64'h0000_0000_0000_0D0D, "R5");
    update(PC_A, 64'h0000_0000_0000_0D0D, 1'b1);              // 1
    lookup(PC_A, 1'b0, 1'b1, 64'h0000_0000_0000_0D0D, "R5");
    update(PC_A, 64'h0000_0000_0000_0D0D, 1'b1);              // 2
    lookup(PC_A, 1'b1, 1'b1, 64'h0000_0000_0000_0D0D, "R5");
  endtask

  task automatic t_value_tag;
    update(PC_E, 64'h1111_EEEE_0000_0000, 1'b0);
    update(PC_E, 64'h1111_EEEE_0000_0000, 1'b1);
    update(PC_E, 64'h1111_EEEE_0000_0000, 1'b1);
    lookup(PC_E, 1'b1, 1'b1, 64'h1111_EEEE_0000_0000, "R8");
    lookup(PC_EX, 1'b0, 1'b0, 64'd0, "R8");
    update(PC_EX, 64'h2222_FFFF_0000_0000, 1'b0);
    lookup(PC_EX, 1'b0, 1'b1, 64'h2222_FFFF_0000_0000, "R8");
    lookup(PC_E, 1'b0, 1'b0, 64'd0, "R8");
  endtask

  task automatic t_conf_tag;
    update(PC_P, 64'h0000_5555_0000_5555, 1'b0);
    update(PC_P, 64'h0000_5555_0000_5555, 1'b1);
    update(PC_P, 64'h0000_5555_0000_5555, 1'b1);
    lookup(PC_P, 1'b1, 1'b1, 64'h0000_5555_0000_5555, "R9");
    update(PC_Q, 64'h0000_6666_0000_6666, 1'b0);
    lookup(PC_P, 1'b0, 1'b1, 64'h0000_5555_0000_5555, "R9");
    update(PC_P, 64'h0000_5555_0000_5555, 1'b1);              // restarts at 1
    lookup(PC_P, 1'b0, 1'b1, 64'h0000_5555_0000_5555, "R9");
    update(PC_P, 64'h0000_5555_0000_5555, 1'b1);              // 2
    lookup(PC_P, 1'b1, 1'b1, 64'h0000_5555_0000_5555, "R9");
  endtask

  task automatic t_same_cycle;
    update(PC_X, 64'h0000_0000_0000_0001, 1'b0);
    @(negedge clk);
    lk_req = 1'b1; lk_pc = PC_X;
    up_req = 1'b1; up_pc = PC_X; up_value = 64'h0000_0000_0000_0002; up_match = 1'b0;
    @(negedge clk);
    up_req = 1'b0;
    check("R10", "same-cycle value", lk_value_o, 64'h1);
    check("R10", "same-cycle valid", {63'd0, lk_valid_o}, 64'd1);
    @(negedge clk);
    check("R10", "next-cycle value", lk_value_o, 64'h1);
    @(negedge clk);
    lk_req = 1'b0;
    check("R10", "two-cycle value", lk_value_o, 64'h2);
    check("R10", "use stays low", {63'd0, lk_use_o}, 64'd0);
  endtask

  task automatic t_back_to_back;
    @(negedge clk);
    up_req = 1'b1; up_pc = PC_Y; up_value = 64'h7777_0000_7777_0000; up_match = 1'b0;
    @(negedge clk);
    up_match = 1'b1;
    @(negedge clk);
    @(negedge clk);
    up_req = 1'b0;
    lookup(PC_Y, 1'b1, 1'b1, 64'h7777_0000_7777_0000, "R11");
  endtask

  initial begin
    t_reset();
    t_alloc();
    t_train_and_lock();
    t_decay();
    t_value_tag();
    t_conf_tag();
    t_same_cycle();
    t_back_to_back();
    repeat (2) @(negedge clk);
    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      n_checks++;
      n_fail++;
      $display("FAIL R2 watchdog: actual=timeout expected=completion");
      $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
      $finish;
    end
  end

endmodule